// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Routing Controller

This block collects up to thirty-two system interrupt sources and up to four processors' private interrupt requests, and turns them into one 4-bit priority level per processor. System sources are captured each cycle into a system pending register. They pass through a system mask that software changes only through write-one-to-set and write-one-to-clear addresses, so several agents can adjust different bits without a read-modify-write. A set bit in the mask blocks its source. The top mask bit blocks all system sources together.

Each processor owns a pending register. Bit n of that register is hard level n and bit 16+n is soft level n. Any agent on the bus can post or retract these bits through that processor's own set and clear addresses, which is how inter-processor interrupts are signalled. System sources go to exactly one processor, chosen by a readable and writable target register. Each processor's level output is the highest level that its own pending bits request, combined with the levels of the unmasked system sources when that processor is the target.

Top module: `irq_route_top`

## Requirements
- R1: After reset the system mask reads 0xFFFFFFFF, the system pending register, the target register and every processor pending register read 0, and every level output is 0.
- R2: A write to the system mask set address (bank offset 0xC) sets each mask bit whose data bit is 1. A write to the mask clear address (offset 0x8) clears each mask bit whose data bit is 1. Bits written as 0 keep their value. The mask reads back at offset 0x4.
- R3: While mask bit 31 is 1, no system source affects any level output, whatever the other mask bits hold.
- R4: The system pending register (offset 0x0 of the system bank) reads the value of the source inputs sampled at the previous clock edge.
- R5: Processor c's pending register reads at offset 0x0 of its bank. A write to offset 0x8 of that bank sets the bits written as 1, and a write to offset 0x4 clears the bits written as 1. Bits written as 0 keep their value, and other processors' registers do not change.
- R6: From its own pending register, a processor's level is the highest n in 1..15 for which bit n or bit 16+n is 1. Bit 0 and bit 16 request no level.
- R7: An unmasked system source requests a level from its bit position. Bits 0 or 7 request level 2. Bits 1 or 8 request level 3. Bit 18 requests 4. Bits 2 or 9 request 5. Bit 16 requests 6. Bits 3 or 10 request 7. Bit 20 requests 8. Bits 4, 11 or 30 request 9. Bit 19 requests 10. Bits 5, 12 or 22 request 11. Bits 14 or 15 request 12. Bits 6, 13 or 17 request 13. Bits 28 or 29 request 15. All other bits request no level.
- R8: Only the processor named by the target register (system bank offset 0x10) receives system-source levels. The register keeps the low two bits of the data written and reads them back zero-extended.
- R9: A processor's level output is the larger of the level from its own pending bits and the level from the system sources routed to it.
- R10: Processor c's bank starts at byte address c×0x1000, and the system bank starts at 0x4000. Writes to read-only offsets or to unmapped addresses change no state, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 16 | Byte address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 16 | Byte address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| srcIn | input | 32 | Raw system interrupt source levels |
| cpuLevel | output | 16 | Priority level per processor, 4 bits each, processor c at bits 4c+3..4c |

## Verification
The hardest situation to reach is the interaction of three independent gates on one source: the per-bit mask, the mask-all bit and the target register. A fault in any one of them is hidden whenever another gate already blocks the source. The stimulus opens every gate but one and then toggles the remaining gate alone, for example moving the target while the mask is fully open. It also walks a single active source through all 32 bit positions with the mask fully open, so that each entry of the level map is observed by itself and is not masked by a higher-priority request.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int CPU_MAX   = 4;
  localparam int CPU_IDX_W = $clog2(CPU_MAX);
  localparam int WORD_W    = 32;
  localparam int LVL_W     = 4;
  localparam int NUM_LVL   = 1 << LVL_W;

  // bank-relative byte offsets
  localparam int OFF_PEND   = 'h0;
  localparam int OFF_CPUCLR = 'h4;
  localparam int OFF_CPUSET = 'h8;
  localparam int OFF_MASK   = 'h4;
  localparam int OFF_MCLR   = 'h8;
  localparam int OFF_MSET   = 'hC;
  localparam int OFF_TGT    = 'h10;

  localparam int MASK_ALL_BIT = 31;

  typedef struct packed {
    logic [CPU_MAX-1:0] cpuSet;
    logic [CPU_MAX-1:0] cpuClr;
    logic               maskSet;
    logic               maskClr;
    logic               tgtWr;
  } wrStrb_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CPUPEND,
    RD_SYSPEND,
    RD_MASK,
    RD_TGT
  } rdSel_t;

  // level request vector raised by a set of active system sources
  function automatic logic [NUM_LVL-1:0] sysLevelReq(input logic [WORD_W-1:0] a);
    logic [NUM_LVL-1:0] r;
    r     = '0;
    r[2]  = a[0] | a[7];
    r[3]  = a[1] | a[8];
    r[4]  = a[18];
    r[5]  = a[2] | a[9];
    r[6]  = a[16];
    r[7]  = a[3] | a[10];
    r[8]  = a[20];
    r[9]  = a[4] | a[11] | a[30];
    r[10] = a[19];
    r[11] = a[5] | a[12] | a[22];
    r[12] = a[14] | a[15];
    r[13] = a[6] | a[13] | a[17];
    r[15] = a[28] | a[29];
    return r;
  endfunction

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  parameter int PAGE_SH = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [ADDR_W-1:0]    rdAddr,
  output wrStrb_t              strb,
  output rdSel_t               rdSel,
  output logic [CPU_IDX_W-1:0] rdCpu
);

  localparam int PG_W = ADDR_W - PAGE_SH;

  logic [PG_W-1:0]    wPage, rPage;
  logic [PAGE_SH-1:0] wOff, rOff;

  assign wPage = wrAddr[ADDR_W-1:PAGE_SH];
  assign wOff  = wrAddr[PAGE_SH-1:0];
  assign rPage = rdAddr[ADDR_W-1:PAGE_SH];
  assign rOff  = rdAddr[PAGE_SH-1:0];

  // write decode
  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (int'(wPage) < NUM_CPU) begin
        for (int c = 0; c < CPU_MAX; c++) begin
          if (c < NUM_CPU && int'(wPage) == c) begin
            if (int'(wOff) == OFF_CPUSET) strb.cpuSet[c] = 1'b1;
            if (int'(wOff) == OFF_CPUCLR) strb.cpuClr[c] = 1'b1;
          end
        end
      end else if (int'(wPage) == NUM_CPU) begin
        if (int'(wOff) == OFF_MSET) strb.maskSet = 1'b1;
        if (int'(wOff) == OFF_MCLR) strb.maskClr = 1'b1;
        if (int'(wOff) == OFF_TGT)  strb.tgtWr   = 1'b1;
      end
    end
  end

  // read decode
  always_comb begin
    rdSel = RD_ZERO;
    rdCpu = '0;
    if (int'(rPage) < NUM_CPU) begin
      for (int c = 0; c < CPU_MAX; c++) begin
        if (c < NUM_CPU && int'(rPage) == c) rdCpu = CPU_IDX_W'(c);
      end
      if (int'(rOff) == OFF_PEND) rdSel = RD_CPUPEND;
    end else if (int'(rPage) == NUM_CPU) begin
      if (int'(rOff) == OFF_PEND) rdSel = RD_SYSPEND;
      if (int'(rOff) == OFF_MASK) rdSel = RD_MASK;
      if (int'(rOff) == OFF_TGT)  rdSel = RD_TGT;
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.maskSet, strb.maskClr, strb.tgtWr, strb.cpuSet, strb.cpuClr}));

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (strb == '0));

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int TGT_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wrStrb_t              strb,
  input  rdSel_t               rdSel,
  input  logic [CPU_IDX_W-1:0] rdCpu,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [WORD_W-1:0]    srcIn,
  output logic [WORD_W-1:0]    rdData,
  output logic [WORD_W-1:0]    cpuPend [NUM_CPU],
  output logic [WORD_W-1:0]    sysAct,
  output logic [TGT_W-1:0]     target,
  output logic                 maskAll
);

  logic [WORD_W-1:0] sysPend, sysMask;
  logic [WORD_W-1:0] mSetV, mClrV;

  assign mSetV = strb.maskSet ? wrData : '0;
  assign mClrV = strb.maskClr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sysPend <= '0;
      sysMask <= '1;
      target  <= '0;
    end else begin
      sysPend <= srcIn;
      sysMask <= (sysMask & ~mClrV) | mSetV;
      if (strb.tgtWr) target <= wrData[TGT_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [WORD_W-1:0] pSetV, pClrV;
    assign pSetV = strb.cpuSet[c] ? wrData : '0;
    assign pClrV = strb.cpuClr[c] ? wrData : '0;

    always_ff @(posedge clk) begin
      if (rst) cpuPend[c] <= '0;
      else     cpuPend[c] <= (cpuPend[c] & ~pClrV) | pSetV;
    end

    // R5
    cpu_post_chk: assert property (@(posedge clk) disable iff (rst)
      strb.cpuSet[c] |=> ((cpuPend[c] & $past(wrData)) == $past(wrData)));

    // R5
    cpu_retract_chk: assert property (@(posedge clk) disable iff (rst)
      strb.cpuClr[c] |=> ((cpuPend[c] & $past(wrData)) == '0));
  end

  assign maskAll = sysMask[MASK_ALL_BIT];
  assign sysAct  = maskAll ? '0 : (sysPend & ~sysMask);

  always_comb begin
    unique case (rdSel)
      RD_CPUPEND: rdData = cpuPend[rdCpu];
      RD_SYSPEND: rdData = sysPend;
      RD_MASK:    rdData = sysMask;
      RD_TGT:     rdData = WORD_W'(target);
      default:    rdData = '0;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sysMask == '1 && target == '0 && sysPend == '0));

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    strb.maskSet |=> ((sysMask & $past(wrData)) == $past(wrData)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    strb.maskClr |=> ((sysMask & $past(wrData)) == '0));

  // R8
  target_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.tgtWr |=> $stable(target));

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cpuPend,
  input  logic [WORD_W-1:0] sysAct,
  input  logic              isTarget,
  output logic [LVL_W-1:0]  level
);

  logic [NUM_LVL-1:0] ownReq, sysReq, allReq;

  always_comb begin
    ownReq = '0;
    for (int n = 1; n < NUM_LVL; n++) begin
      ownReq[n] = cpuPend[n] | cpuPend[16 + n];
    end
  end

  assign sysReq = isTarget ? sysLevelReq(sysAct) : '0;
  assign allReq = ownReq | sysReq;

  always_comb begin
    level = '0;
    for (int n = 1; n < NUM_LVL; n++) begin
      if (allReq[n]) level = LVL_W'(n);
    end
  end

  // R6
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuPend[15] | cpuPend[31]) |-> (level == LVL_W'(15)));

  // R8
  non_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!isTarget && cpuPend == '0) |-> (level == '0));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16,
  parameter int PAGE_SH = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [WORD_W-1:0]        rdData,
  input  logic [WORD_W-1:0]        srcIn,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);

  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  wrStrb_t              strb;
  rdSel_t               rdSel;
  logic [CPU_IDX_W-1:0] rdCpu;
  logic [WORD_W-1:0]    cpuPend [NUM_CPU];
  logic [WORD_W-1:0]    sysAct;
  logic [TGT_W-1:0]     target;
  logic                 maskAll;

  irq_route_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strb(strb), .rdSel(rdSel), .rdCpu(rdCpu)
  );

  irq_route_dp #(.NUM_CPU(NUM_CPU), .TGT_W(TGT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .rdSel(rdSel), .rdCpu(rdCpu),
    .wrData(wrData), .srcIn(srcIn), .rdData(rdData), .cpuPend(cpuPend),
    .sysAct(sysAct), .target(target), .maskAll(maskAll)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_enc
    logic [LVL_W-1:0] lvl;

    irq_level_enc u_enc (
      .clk(clk), .rst(rst), .cpuPend(cpuPend[c]), .sysAct(sysAct),
      .isTarget(int'(target) == c), .level(lvl)
    );

    assign cpuLevel[c*LVL_W +: LVL_W] = lvl;

    // R3
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
      (maskAll && cpuPend[c] == '0) |-> (lvl == '0));
  end

endmodule

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic [15:0] cpuLevel;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] SYS   = 16'h4000;
  localparam logic [15:0] SPEND = SYS + 16'h0;
  localparam logic [15:0] SMASK = SYS + 16'h4;
  localparam logic [15:0] SCLR  = SYS + 16'h8;
  localparam logic [15:0] SSET  = SYS + 16'hC;
  localparam logic [15:0] STGT  = SYS + 16'h10;

  always #2 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcIn(srcIn), .cpuLevel(cpuLevel)
  );

  function automatic logic [15:0] cpuBase(int c);
    return 16'(c * 16'h1000);
  endfunction

  function automatic logic [3:0] expSysLvl(int b);
    case (b)
      0, 7:       return 4'd2;
      1, 8:       return 4'd3;
      18:         return 4'd4;
      2, 9:       return 4'd5;
      16:         return 4'd6;
      3, 10:      return 4'd7;
      20:         return 4'd8;
      4, 11, 30:  return 4'd9;
      19:         return 4'd10;
      5, 12, 22:  return 4'd11;
      14, 15:     return 4'd12;
      6, 13, 17:  return 4'd13;
      28, 29:     return 4'd15;
      default:    return 4'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(logic [15:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic setSrc(logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] lvl(int c);
    return 32'(cpuLevel[c*4 +: 4]);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    busRead(SMASK, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    busRead(SPEND, d); chk("R1 syspend", d, 0);
    busRead(STGT, d);  chk("R1 target", d, 0);
    for (int c = 0; c < 4; c++) begin
      busRead(cpuBase(c), d); chk("R1 cpupend", d, 0);
      chk("R1 level", lvl(c), 0);
    end
  endtask

  task automatic t_mask();
    logic [31:0] d;
    busWrite(SCLR, 32'h0000_00FF);
    busRead(SMASK, d); chk("R2 clear", d, 32'hFFFF_FF00);
    busWrite(SCLR, 32'h0);
    busRead(SMASK, d); chk("R2 zero clear", d, 32'hFFFF_FF00);
    busWrite(SSET, 32'h0000_0003);
    busRead(SMASK, d); chk("R2 set", d, 32'hFFFF_FF03);
    busWrite(SSET, 32'h0);
    busRead(SMASK, d); chk("R2 zero set", d, 32'hFFFF_FF03);
    busWrite(SCLR, 32'h8000_0001);
    busRead(SMASK, d); chk("R2 clear top", d, 32'h7FFF_FF02);
    busWrite(SSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_cpuPend();
    logic [31:0] d;
    busWrite(cpuBase(1) + 16'h8, 32'h20);
    busRead(cpuBase(1), d); chk("R5 post", d, 32'h20);
    chk("R6 level5", lvl(1), 5);
    chk("R5 other cpu level", lvl(0), 0);
    busWrite(cpuBase(1) + 16'h8, 32'h1 << 25);
    chk("R6 soft9", lvl(1), 9);
    busWrite(cpuBase(1) + 16'h8, 32'h1);
    chk("R6 bit0 no level", lvl(1), 9);
    busRead(cpuBase(1), d); chk("R5 accumulate", d, 32'h0200_0021);
    busWrite(cpuBase(1) + 16'h4, 32'h1 << 25);
    chk("R6 after retract", lvl(1), 5);
    busWrite(cpuBase(1) + 16'h4, 32'h0);
    busRead(cpuBase(1), d); chk("R5 zero clear", d, 32'h21);
    busRead(cpuBase(2), d); chk("R5 cpu2 untouched", d, 0);
    busWrite(cpuBase(1) + 16'h4, 32'hFFFF_FFFF);
    busRead(cpuBase(1), d); chk("R5 clear all", d, 0);
    busWrite(cpuBase(3) + 16'h8, 32'h1 << 30);
    chk("R6 soft14", lvl(3), 14);
    busWrite(cpuBase(3) + 16'h8, 32'h1 << 16);
    chk("R6 bit16 no level", lvl(3), 14);
    busWrite(cpuBase(3) + 16'h4, 32'hFFFF_FFFF);
    chk("R6 cleared", lvl(3), 0);
  endtask

  task automatic t_sysMap();
    logic [31:0] d;
    busWrite(SCLR, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      setSrc(32'h1 << b);
      // bit 31 is the mask-all position; it requests no level
      chk($sformatf("R7 bit%0d", b), lvl(0), 32'(expSysLvl(b)));
      if (b % 8 == 3) begin
        busRead(SPEND, d); chk("R4 syspend", d, 32'h1 << b);
        chk("R8 not target", lvl(1), 0);
      end
    end
    setSrc(32'h0008_0001);
    busRead(SPEND, d); chk("R4 two sources", d, 32'h0008_0001);
    chk("R7 highest of two", lvl(0), 10);
    setSrc(0);
    busWrite(SSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_maskAll();
    busWrite(SCLR, 32'h7FFF_FFFF);
    setSrc(32'h1 << 19);
    chk("R3 mask-all blocks", lvl(0), 0);
    busWrite(SCLR, 32'h8000_0000);
    chk("R3 mask-all open", lvl(0), 10);
    busWrite(SSET, 32'h1 << 19);
    chk("R2 bit mask blocks", lvl(0), 0);
    busWrite(SCLR, 32'h1 << 19);
    busWrite(SSET, 32'h8000_0000);
    chk("R3 mask-all reblocks", lvl(0), 0);
    setSrc(0);
    busWrite(SSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_target();
    logic [31:0] d;
    busWrite(SCLR, 32'hFFFF_FFFF);
    setSrc(32'h1 << 17);
    chk("R8 target0", lvl(0), 13);
    busWrite(STGT, 32'h2);
    chk("R8 target2 gets", lvl(2), 13);
    chk("R8 cpu0 loses", lvl(0), 0);
    busRead(STGT, d); chk("R8 readback", d, 2);
    busWrite(STGT, 32'h7);
    busRead(STGT, d); chk("R8 low bits", d, 3);
    chk("R8 target3 gets", lvl(3), 13);
    chk("R8 cpu2 loses", lvl(2), 0);
    busWrite(STGT, 32'h0);
    setSrc(0);
    busWrite(SSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_combine();
    busWrite(SCLR, 32'hFFFF_FFFF);
    setSrc(32'h1 << 19);
    busWrite(cpuBase(0) + 16'h8, 32'h1 << 12);
    chk("R9 own higher", lvl(0), 12);
    setSrc(32'h1 << 17);
    chk("R9 system higher", lvl(0), 13);
    busWrite(cpuBase(0) + 16'h4, 32'hFFFF_FFFF);
    chk("R9 system only", lvl(0), 13);
    setSrc(0);
    chk("R9 none", lvl(0), 0);
    busWrite(SSET, 32'hFFFF_FFFF);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    busWrite(cpuBase(0), 32'hFFFF_FFFF);
    busRead(cpuBase(0), d); chk("R10 ro cpu pend", d, 0);
    chk("R10 ro cpu level", lvl(0), 0);
    busWrite(SPEND, 32'h0000_FFFF);
    busRead(SMASK, d); chk("R10 ro sys pend", d, 32'hFFFF_FFFF);
    busWrite(SMASK, 32'h0);
    busRead(SMASK, d); chk("R10 ro mask", d, 32'hFFFF_FFFF);
    busWrite(16'h5008, 32'hFFFF_FFFF);
    busWrite(16'h4014, 32'hFFFF_FFFF);
    busRead(SMASK, d); chk("R10 unmapped write mask", d, 32'hFFFF_FFFF);
    chk("R10 unmapped write levels", 32'(cpuLevel), 0);
    busRead(16'h6000, d); chk("R10 unmapped read", d, 0);
    busRead(16'h4014, d); chk("R10 unmapped offset read", d, 0);
    busWrite(cpuBase(2) + 16'h8, 32'h40);
    busRead(cpuBase(2), d); chk("R10 bank 2 pend", d, 32'h40);
    busRead(cpuBase(1), d); chk("R10 bank 1 separate", d, 0);
    busWrite(cpuBase(2) + 16'h4, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_cpuPend();
    t_sysMap();
    t_maskAll();
    t_target();
    t_combine();
    t_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule